// File: doc/BRIEF.md
# SCSI Selection Response Filter

This block watches a parallel SCSI bus, 8 or 16 data lines wide, while another device selects or reselects, and decides whether the local target should respond. It waits until SEL is asserted, BSY is released and the data and parity lines have held still for two clocks. It then checks the asserted ID bits and the odd byte parity against the target's configured ID and three policy bits. It answers each selection event with at most one one-cycle pulse. An accept pulse comes with the initiator ID it decoded. A reject pulse marks a selection that was meant for this target but was malformed or corrupted. A selection that is not meant for this target, or that policy says to ignore, gives no pulse at all.

A small write/readback register holds the target ID and the policy bits, and it clears to zero on reset. At its reset value both optional filters are off: SCSI-1 single-initiator selections are answered, and the high data byte is neither decoded nor parity checked. Selection and reselection are filtered the same way. Arbitration, the selection timeout, the phase sequencing that follows selection and the bus drivers all sit outside this block.

Top module: `scsi_sel_filter`

## Requirements
- R1: The configuration register resets to all zeros. A write with `cfg_we_i` high loads `cfg_wdata_i` at the next rising edge, and `cfg_rdata_o` always shows the stored value. Its fields are: bits 3:0 the target ID, bit 4 the parity check enable, bit 5 the single-initiator reject enable, and bit 6 the 16-bit system enable.
- R2: A decision is taken at the second rising edge at which SEL=1 and BSY=0 with data and parity unchanged since the previous edge. The result appears in the cycle after that edge. A change of data or parity while SEL is held restarts the two-edge wait.
- R3: Each selection event gives at most one decision. `accept_o` and `reject_o` each last one cycle. No new decision is taken until SEL drops or BSY rises.
- R4: If the target's own ID bit is not asserted among the decoded ID lines, no pulse is given. The decoded lines are data bits 7:0 when bit 6 is clear and bits 15:0 when it is set.
- R5: An otherwise valid selection with exactly two decoded ID bits, one of them the target's, is accepted. `init_vld_o`=1 and `init_id_o` holds the bit index of the other ID during the accept cycle. Outside that cycle both are 0.
- R6: A selection showing only the target's own ID is accepted with `init_vld_o`=0 when bit 5 is clear, and gives no pulse when bit 5 is set.
- R7: Parity is odd per byte: `bus_par_i[0]` covers data 7:0 and `bus_par_i[1]` covers data 15:8. With bit 4 set, a low-byte failure (XOR of the byte and its parity bit equal to 0) gives a reject, whatever the high byte shows. With bit 4 clear, parity has no effect.
- R8: With bits 4 and 6 both set and the low byte correct, a high-byte parity failure gives no pulse. With bit 6 clear, data 15:8 and `bus_par_i[1]` have no effect.
- R9: A selection for this target with valid parity and more than two decoded ID bits asserted is rejected.
- R10: `accept_o` and `reject_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 7 | Configuration write data |
| cfg_rdata_o | output | 7 | Configuration readback |
| bus_data_i | input | 16 | SCSI data lines, logical level (1 = asserted) |
| bus_par_i | input | 2 | Parity per byte, bit 0 low byte, bit 1 high byte |
| bus_sel_i | input | 1 | SEL, logical level |
| bus_bsy_i | input | 1 | BSY, logical level |
| accept_o | output | 1 | One-cycle accept pulse |
| reject_o | output | 1 | One-cycle reject pulse |
| init_vld_o | output | 1 | Initiator ID valid, during accept only |
| init_id_o | output | 4 | Decoded initiator ID, during accept only |

## Verification
Bus values are driven at a falling edge. They are captured at the next rising edge and confirmed at the one after, so a decision is due at the second falling edge after the drive. The bench samples exactly there, then checks at the following falling edge that the pulse has ended. A configuration write is checked one falling edge after the strobe. For the restart case, the bench changes the data one cycle into the wait, checks that no pulse appears two edges after the first drive, and then expects the decision on the new value one cycle later.

// File: rtl/scsi_sel_pkg.sv
package scsi_sel_pkg;
  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_ACCEPT = 2'd1,
    SEL_REJECT = 2'd2
  } sel_out_e;

  localparam int unsigned CFG_EXTRA = 3;  // par_en, no_single, wide
endpackage

// File: rtl/sel_cfg_reg.sv
module sel_cfg_reg #(
  parameter int unsigned CFG_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] cfg_o
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= wdata_i;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/sel_sampler.sv
module sel_sampler #(
  parameter int unsigned BUS_W = 16,
  parameter int unsigned NB    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BUS_W-1:0] data_i,
  input  logic [NB-1:0]    par_i,
  input  logic             sel_i,
  input  logic             bsy_i,
  output logic             fire_o
);
  logic [BUS_W-1:0] data_q;
  logic [NB-1:0]    par_q;
  logic             cond_q;
  logic             done_q;
  logic             cond;
  logic             stable;

  assign cond   = sel_i & ~bsy_i;
  assign stable = cond & cond_q & (data_i == data_q) & (par_i == par_q);
  assign fire_o = stable & ~done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      par_q  <= '0;
      cond_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      data_q <= data_i;
      par_q  <= par_i;
      cond_q <= cond;
      // one decision per event; re-armed only when the selection ends
      done_q <= cond ? (done_q | fire_o) : 1'b0;
    end
  end
endmodule

// File: rtl/sel_decide.sv
module sel_decide
  import scsi_sel_pkg::*;
#(
  parameter int unsigned ID_W  = 4,
  parameter int unsigned BUS_W = 16,
  parameter int unsigned NB    = 2
) (
  input  logic [BUS_W-1:0] data_i,
  input  logic [NB-1:0]    par_i,
  input  logic [ID_W-1:0]  own_id_i,
  input  logic             par_en_i,
  input  logic             no_single_i,
  input  logic             wide_i,
  output sel_out_e         out_o,
  output logic             vld_o,
  output logic [ID_W-1:0]  id_o
);
  localparam int unsigned CNT_W = ID_W + 1;

  logic [NB-1:0]    lane_en;
  logic [NB-1:0]    par_bad;
  logic [BUS_W-1:0] ids;
  logic [BUS_W-1:0] others;
  logic [CNT_W-1:0] cnt;
  logic             lo_fail;
  logic             hi_fail;
  logic             own_hit;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    if (b == 0) begin : g_base
      assign lane_en[b] = 1'b1;
    end else begin : g_ext
      assign lane_en[b] = wide_i;
    end
    assign par_bad[b]      = lane_en[b] & ~(^{data_i[b*8 +: 8], par_i[b]});
    assign ids[b*8 +: 8]   = lane_en[b] ? data_i[b*8 +: 8] : 8'h00;
  end

  assign lo_fail = par_en_i & par_bad[0];

  if (NB > 1) begin : g_hi
    assign hi_fail = par_en_i & (|par_bad[NB-1:1]);
  end else begin : g_nohi
    assign hi_fail = 1'b0;
  end

  assign own_hit = ids[own_id_i];
  assign others  = ids & ~(BUS_W'(1) << own_id_i);

  always_comb begin
    cnt = '0;
    for (int i = 0; i < BUS_W; i++) cnt = cnt + CNT_W'(ids[i]);
  end

  always_comb begin
    id_o = '0;
    for (int i = BUS_W - 1; i >= 0; i--)
      if (others[i]) id_o = ID_W'(i);
  end

  always_comb begin
    out_o = SEL_NONE;
    vld_o = 1'b0;
    if (!own_hit)                 out_o = SEL_NONE;
    else if (lo_fail)             out_o = SEL_REJECT;
    else if (hi_fail)             out_o = SEL_NONE;    // undriven high byte: stay silent
    else if (cnt > CNT_W'(2))     out_o = SEL_REJECT;
    else if (cnt == CNT_W'(1))    out_o = no_single_i ? SEL_NONE : SEL_ACCEPT;
    else begin
      out_o = SEL_ACCEPT;
      vld_o = 1'b1;
    end
  end
endmodule

// File: rtl/scsi_sel_filter.sv
module scsi_sel_filter
  import scsi_sel_pkg::*;
#(
  parameter int unsigned ID_W = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cfg_we_i,
  input  logic [ID_W+CFG_EXTRA-1:0]    cfg_wdata_i,
  output logic [ID_W+CFG_EXTRA-1:0]    cfg_rdata_o,
  input  logic [(1<<ID_W)-1:0]         bus_data_i,
  input  logic [(1<<ID_W)/8-1:0]       bus_par_i,
  input  logic                         bus_sel_i,
  input  logic                         bus_bsy_i,
  output logic                         accept_o,
  output logic                         reject_o,
  output logic                         init_vld_o,
  output logic [ID_W-1:0]              init_id_o
);
  localparam int unsigned BUS_W  = 1 << ID_W;
  localparam int unsigned NB     = BUS_W / 8;
  localparam int unsigned CFG_W  = ID_W + CFG_EXTRA;
  localparam int unsigned PE_BIT = ID_W;
  localparam int unsigned NS_BIT = ID_W + 1;
  localparam int unsigned WD_BIT = ID_W + 2;

  logic [CFG_W-1:0] cfg;
  logic             fire;
  sel_out_e         dec_out;
  logic             dec_vld;
  logic [ID_W-1:0]  dec_id;

  sel_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .wdata_i(cfg_wdata_i),
    .cfg_o  (cfg)
  );

  sel_sampler #(.BUS_W(BUS_W), .NB(NB)) u_smp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .data_i(bus_data_i),
    .par_i (bus_par_i),
    .sel_i (bus_sel_i),
    .bsy_i (bus_bsy_i),
    .fire_o(fire)
  );

  sel_decide #(.ID_W(ID_W), .BUS_W(BUS_W), .NB(NB)) u_dec (
    .data_i     (bus_data_i),
    .par_i      (bus_par_i),
    .own_id_i   (cfg[ID_W-1:0]),
    .par_en_i   (cfg[PE_BIT]),
    .no_single_i(cfg[NS_BIT]),
    .wide_i     (cfg[WD_BIT]),
    .out_o      (dec_out),
    .vld_o      (dec_vld),
    .id_o       (dec_id)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o   <= 1'b0;
      reject_o   <= 1'b0;
      init_vld_o <= 1'b0;
      init_id_o  <= '0;
    end else begin
      accept_o   <= fire & (dec_out == SEL_ACCEPT);
      reject_o   <= fire & (dec_out == SEL_REJECT);
      init_vld_o <= fire & (dec_out == SEL_ACCEPT) & dec_vld;
      init_id_o  <= (fire && dec_out == SEL_ACCEPT && dec_vld) ? dec_id : '0;
    end
  end

  assign cfg_rdata_o = cfg;
endmodule

// File: rtl/sel_filter_chk.sv
module sel_filter_chk #(
  parameter int unsigned ID_W = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [ID_W+2:0]         cfg_rdata_o,
  input logic [(1<<ID_W)-1:0]    bus_data_i,
  input logic [(1<<ID_W)/8-1:0]  bus_par_i,
  input logic                    bus_sel_i,
  input logic                    bus_bsy_i,
  input logic                    accept_o,
  input logic                    reject_o,
  input logic                    init_vld_o
);
  logic armed;
  assign armed = bus_sel_i & ~bus_bsy_i;

  assert_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept_o && reject_o));

  assert_accept_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !accept_o && !reject_o);

  assert_reject_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |=> !reject_o && !accept_o);

  assert_two_edges_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o || reject_o) |-> $past(armed, 1) && $past(armed, 2));

  assert_stable_bus_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o || reject_o) |-> $past(bus_data_i, 1) == $past(bus_data_i, 2));

  assert_own_bit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (($past(bus_data_i) >> $past(cfg_rdata_o[ID_W-1:0])) & 1) != 0);

  assert_lo_parity_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && $past(cfg_rdata_o[ID_W])) |-> (^{$past(bus_data_i[7:0]), $past(bus_par_i[0])}) == 1'b1);

  assert_vld_in_accept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_vld_o |-> accept_o);
endmodule

bind scsi_sel_filter sel_filter_chk #(.ID_W(ID_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_rdata_o(cfg_rdata_o),
  .bus_data_i (bus_data_i),
  .bus_par_i  (bus_par_i),
  .bus_sel_i  (bus_sel_i),
  .bus_bsy_i  (bus_bsy_i),
  .accept_o   (accept_o),
  .reject_o   (reject_o),
  .init_vld_o (init_vld_o)
);

// File: tb/scsi_sel_filter_tb.sv
module scsi_sel_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_wdata = '0;
  logic [6:0]  cfg_rdata;
  logic [15:0] data = '0;
  logic [1:0]  par = '0;
  logic        sel = 1'b0;
  logic        bsy = 1'b0;
  logic        acc, rej, vld;
  logic [3:0]  iid;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  scsi_sel_filter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .bus_data_i(data), .bus_par_i(par),
    .bus_sel_i(sel), .bus_bsy_i(bsy), .accept_o(acc), .reject_o(rej),
    .init_vld_o(vld), .init_id_o(iid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // {acc, rej, vld, id[3:0]}
  function automatic logic [6:0] model(input logic [15:0] d, input logic [1:0] p, input logic [6:0] c);
    logic [3:0]  own  = c[3:0];
    logic        pe   = c[4];
    logic        dsi  = c[5];
    logic        wide = c[6];
    logic [15:0] ids  = wide ? d : {8'h00, d[7:0]};
    logic        lo_ok = ^{d[7:0], p[0]};
    logic        hi_ok = ^{d[15:8], p[1]};
    int          cnt = $countones(ids);
    logic [3:0]  oth = '0;
    for (int i = 15; i >= 0; i--) if (ids[i] && i != int'(own)) oth = 4'(i);
    if (!ids[own])              return 7'b000_0000;
    if (pe && !lo_ok)           return 7'b010_0000;
    if (pe && wide && !hi_ok)   return 7'b000_0000;
    if (cnt > 2)                return 7'b010_0000;
    if (cnt == 1)               return dsi ? 7'b000_0000 : 7'b100_0000;
    return {3'b101, oth};
  endfunction

  function automatic logic [1:0] good_par(input logic [15:0] d);
    return {~^d[15:8], ~^d[7:0]};
  endfunction

  task automatic write_cfg(input logic [6:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R1 cfg write", {25'd0, cfg_rdata}, {25'd0, v});
  endtask

  task automatic run_sel(input string req, input logic [15:0] d, input logic [1:0] p);
    logic [6:0] e = model(d, p, cfg_rdata);
    @(negedge clk);
    data = d; par = p; sel = 1'b1; bsy = 1'b0;
    @(negedge clk);
    check({req, " R2 early"}, {30'd0, acc, rej}, 32'd0);
    @(negedge clk);
    check({req, " decision"}, {25'd0, acc, rej, vld, iid}, {25'd0, e});
    @(negedge clk);
    check({req, " R3 single pulse"}, {30'd0, acc, rej}, 32'd0);
    sel = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_fail++; n_tests++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [1:0]  p;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check("R1 reset cfg", {25'd0, cfg_rdata}, 32'd0);
    check("R1 reset outs", {25'd0, acc, rej, vld, iid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // defaults: single-initiator accepted, parity ignored (R6, R7)
    write_cfg(7'h03);
    run_sel("R6 single default", 16'h0008, 2'b00);
    run_sel("R5 two ids", 16'h0088, good_par(16'h0088));
    run_sel("R4 not ours", 16'h0041, 2'b11);
    run_sel("R9 three ids", 16'h008A, good_par(16'h008A));
    run_sel("R7 parity off bad par", 16'h0018, ~good_par(16'h0018));
    run_sel("R8 narrow ignores hi", 16'hFF0C, 2'b10 ^ good_par(16'hFF0C));
    write_cfg(7'h23);
    run_sel("R6 single rejected silently", 16'h0008, 2'b00);
    write_cfg(7'h13);
    run_sel("R7 lo parity fail", 16'h0028, ~good_par(16'h0028));
    run_sel("R7 lo parity ok", 16'h0028, good_par(16'h0028));
    write_cfg(7'h5B);  // wide, par_en, own=11
    run_sel("R8 hi undriven", 16'h0880, {1'b0, good_par(16'h0880)} ^ 2'b00 | 2'b00);
    run_sel("R8 hi parity bad", 16'h0880, good_par(16'h0880) ^ 2'b10);
    run_sel("R5 wide two ids", 16'h0880, good_par(16'h0880));
    run_sel("R7 lo beats hi", 16'h0880, ~good_par(16'h0880));

    // R2 restart: change data one cycle into the wait
    write_cfg(7'h03);
    @(negedge clk);
    data = 16'h0009; par = 2'b00; sel = 1'b1;
    @(negedge clk);
    data = 16'h000C;
    @(negedge clk);
    check("R2 restart no pulse", {30'd0, acc, rej}, 32'd0);
    @(negedge clk);
    check("R2 restart decision", {25'd0, acc, rej, vld, iid}, {25'd0, 7'b101_0010});
    // R3: held selection gives nothing more; BSY rise re-arms
    repeat (3) @(negedge clk);
    check("R3 held", {30'd0, acc, rej}, 32'd0);
    bsy = 1'b1;
    @(negedge clk);
    bsy = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R3 rearmed", {25'd0, acc, rej, vld, iid}, {25'd0, 7'b101_0010});
    sel = 1'b0;
    @(negedge clk);

    for (int k = 0; k < 300; k++) begin
      logic [6:0] c = 7'($urandom);
      int pat = $urandom % 5;
      logic [3:0] own = c[3:0];
      if (!c[6]) own[3] = ($urandom % 4 == 0);
      c[3:0] = own;
      write_cfg(c);
      case (pat)
        0: d = 16'(1) << own;
        1: d = (16'(1) << own) | (16'(1) << ($urandom % 16));
        2: d = (16'(1) << own) | (16'(1) << ($urandom % 16)) | (16'(1) << ($urandom % 16));
        3: d = (16'(1) << own) | (16'(1) << ($urandom % 8));
        default: d = 16'($urandom);
      endcase
      p = good_par(d);
      if ($urandom % 4 == 0) p ^= 2'($urandom);
      run_sel("R4 R5 R6 R7 R8 R9 random", d, p);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule